// File: doc/BRIEF.md
# Register-Tag Configuration Table Loader

This block keeps a table of sixteen 16-bit register-tag entries, each with a valid flag, that other logic uses to decide how vector-style register accesses are redirected. Software fills the table through eight numbered configuration ports. One write names a port and carries a data word. In narrow mode the word holds two 16-bit entries; in wide mode it holds four. The entries land in consecutive slots starting at twice the port number.

The same write also invalidates every slot above the ones it just loaded. Lower ports must therefore be written before higher ones. A write to a low port throws away everything that later ports had set. A loaded slot counts as valid only when its 16-bit value is nonzero. The whole table is visible on flat output buses. A single indexed read port also returns any one slot and its valid flag.

Writes arrive on a valid/ready interface. The block never applies back-pressure: ready is held high out of reset, and every cycle with valid high is a complete transfer. All changes to the table appear one clock after the transfer.

Top module: `rtag_table_loader`

## Requirements
- R1: While reset is asserted and right after it, every entry reads 0 and every valid flag reads 0.
- R2: In narrow mode (wide_mode = 0), a write to port p stores wr_data[15:0] in slot 2p and wr_data[31:16] in slot 2p+1. wr_data[63:32] has no effect.
- R3: In wide mode (wide_mode = 1), a write to port p additionally stores wr_data[47:32] in slot 2p+2 and wr_data[63:48] in slot 2p+3.
- R4: A write clears to zero, and marks invalid, every slot from 2p+2 (narrow) or 2p+4 (wide) up to slot 15.
- R5: Slots below 2p keep their entry and valid flag across a write to port p.
- R6: A lane whose target slot would be above 15 is dropped and does not wrap. A wide write to port 7 loads only slots 14 and 15.
- R7: A loaded slot's valid flag is 1 exactly when its stored value is nonzero. Cleared slots are 0 and invalid.
- R8: A transfer is visible on the outputs on the clock edge after it. Back-to-back transfers apply in order. Cycles with wr_valid = 0 leave the table unchanged, whatever wr_port and wr_data carry.
- R9: wr_ready is 1 whenever reset is deasserted, so every cycle with wr_valid = 1 is accepted.
- R10: rd_entry and rd_valid show, with no clock delay, the entry and valid flag of slot rd_idx.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wide_mode | input | 1 | 1: four entries per write; 0: two entries per write |
| wr_valid | input | 1 | Write transfer request |
| wr_ready | output | 1 | Always 1 out of reset; no back-pressure |
| wr_port | input | 3 | Configuration port number, 0 to 7 |
| wr_data | input | 64 | Packed entries, lane k in bits 16k+15:16k |
| tbl_entries | output | 256 | All slots, slot s in bits 16s+15:16s |
| tbl_valid | output | 16 | Valid flag per slot, bit s for slot s |
| rd_idx | input | 4 | Slot index for the read port |
| rd_entry | output | 16 | Entry of slot rd_idx |
| rd_valid | output | 1 | Valid flag of slot rd_idx |

## Verification
In one cycle, a single transfer both loads its own slots and wipes every slot above them. A wrong boundary between the two shows up as one slot that is loaded when it should be wiped, or the reverse. The bench fills the whole table with wide writes and then writes mid-table ports in both modes. It compares every slot against a model written from the requirements. This covers slots just below the base, the loaded slots, and the first wiped slot. The wide write to port 7 puts the dropped lanes at the table's end, where a wrap-around would corrupt slots 0 and 1.

// File: rtl/tcfg_pkg.sv
package tcfg_pkg;

  // Per-slot action chosen by the decoder for one cycle
  typedef enum logic [1:0] {
    SLOT_KEEP = 2'd0,
    SLOT_LOAD = 2'd1,
    SLOT_WIPE = 2'd2
  } slot_op_e;

endpackage

// File: rtl/tcfg_slot_decode.sv
module tcfg_slot_decode
  import tcfg_pkg::*;
#(
  parameter int SLOTS        = 16,
  parameter int LANES        = 4,
  parameter int NARROW_LANES = 2,
  parameter int PORT_W       = 3,
  parameter int IDX_W        = 4,
  parameter int LANE_W       = 2
) (
  input  logic                          wr_en,
  input  logic                          wide,
  input  logic [PORT_W-1:0]             port,
  output slot_op_e                      op_o   [SLOTS],
  output logic [SLOTS-1:0][LANE_W-1:0]  lane_o
);

  // Wide enough that base + span never wraps
  localparam int CMP_W = IDX_W + 2;

  logic [CMP_W-1:0] base_w;
  logic [CMP_W-1:0] span_w;
  logic [CMP_W-1:0] limit_w;

  assign base_w  = CMP_W'(port) * CMP_W'(NARROW_LANES);
  assign span_w  = wide ? CMP_W'(LANES) : CMP_W'(NARROW_LANES);
  assign limit_w = base_w + span_w;

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    localparam logic [CMP_W-1:0] SLOT_POS = CMP_W'(s);
    logic [LANE_W-1:0] offs;

    assign offs = LANE_W'(SLOT_POS - base_w);

    always_comb begin
      op_o[s]   = SLOT_KEEP;
      lane_o[s] = '0;
      if (wr_en && (SLOT_POS >= base_w)) begin
        if (SLOT_POS < limit_w) begin
          op_o[s]   = SLOT_LOAD;
          lane_o[s] = offs;
        end else begin
          op_o[s] = SLOT_WIPE;
        end
      end
    end
  end

endmodule

// File: rtl/tcfg_lane_pick.sv
module tcfg_lane_pick #(
  parameter int ENTRY_W = 16,
  parameter int LANES   = 4,
  parameter int LANE_W  = 2
) (
  input  logic [LANES*ENTRY_W-1:0] data_i,
  input  logic [LANE_W-1:0]        sel_i,
  output logic [ENTRY_W-1:0]       entry_o
);

  logic [ENTRY_W-1:0] lane_arr [LANES];

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign lane_arr[k] = data_i[k*ENTRY_W +: ENTRY_W];
  end

  assign entry_o = lane_arr[sel_i];

endmodule

// File: rtl/tcfg_slot_reg.sv
module tcfg_slot_reg
  import tcfg_pkg::*;
#(
  parameter int ENTRY_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  slot_op_e           op_i,
  input  logic [ENTRY_W-1:0] load_i,
  output logic [ENTRY_W-1:0] entry_q,
  output logic               valid_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      entry_q <= '0;
      valid_q <= 1'b0;
    end else begin
      unique case (op_i)
        SLOT_LOAD: begin
          entry_q <= load_i;
          valid_q <= |load_i;
        end
        SLOT_WIPE: begin
          entry_q <= '0;
          valid_q <= 1'b0;
        end
        default: begin
          entry_q <= entry_q;
          valid_q <= valid_q;
        end
      endcase
    end
  end

endmodule

// File: rtl/rtag_table_loader.sv
module rtag_table_loader
  import tcfg_pkg::*;
#(
  parameter int SLOTS   = 16,
  parameter int ENTRY_W = 16,
  parameter int PORTS   = 8,
  parameter int DATA_W  = 64
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wide_mode,
  input  logic                       wr_valid,
  output logic                       wr_ready,
  input  logic [$clog2(PORTS)-1:0]   wr_port,
  input  logic [DATA_W-1:0]          wr_data,
  output logic [SLOTS*ENTRY_W-1:0]   tbl_entries,
  output logic [SLOTS-1:0]           tbl_valid,
  input  logic [$clog2(SLOTS)-1:0]   rd_idx,
  output logic [ENTRY_W-1:0]         rd_entry,
  output logic                       rd_valid
);

  localparam int PORT_W       = $clog2(PORTS);
  localparam int IDX_W        = $clog2(SLOTS);
  localparam int LANES        = DATA_W / ENTRY_W;
  localparam int NARROW_LANES = LANES / 2;
  localparam int LANE_W       = (LANES > 1) ? $clog2(LANES) : 1;

  slot_op_e                     slot_op  [SLOTS];
  logic [SLOTS-1:0][LANE_W-1:0] slot_lane;
  logic [ENTRY_W-1:0]           slot_load [SLOTS];
  logic [ENTRY_W-1:0]           slot_q    [SLOTS];
  logic                         wr_fire;

  // No back-pressure: every valid cycle out of reset is a transfer
  assign wr_ready = rst_n;
  assign wr_fire  = wr_valid && wr_ready;

  tcfg_slot_decode #(
    .SLOTS        (SLOTS),
    .LANES        (LANES),
    .NARROW_LANES (NARROW_LANES),
    .PORT_W       (PORT_W),
    .IDX_W        (IDX_W),
    .LANE_W       (LANE_W)
  ) u_decode (
    .wr_en  (wr_fire),
    .wide   (wide_mode),
    .port   (wr_port),
    .op_o   (slot_op),
    .lane_o (slot_lane)
  );

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    tcfg_lane_pick #(
      .ENTRY_W (ENTRY_W),
      .LANES   (LANES),
      .LANE_W  (LANE_W)
    ) u_pick (
      .data_i  (wr_data),
      .sel_i   (slot_lane[s]),
      .entry_o (slot_load[s])
    );

    tcfg_slot_reg #(
      .ENTRY_W (ENTRY_W)
    ) u_reg (
      .clk     (clk),
      .rst_n   (rst_n),
      .op_i    (slot_op[s]),
      .load_i  (slot_load[s]),
      .entry_q (slot_q[s]),
      .valid_q (tbl_valid[s])
    );

    assign tbl_entries[s*ENTRY_W +: ENTRY_W] = slot_q[s];
  end

  // Combinational indexed read
  assign rd_entry = slot_q[rd_idx];
  assign rd_valid = tbl_valid[rd_idx];

endmodule

// File: rtl/rtag_table_loader_chk.sv
module rtag_table_loader_chk #(
  parameter int SLOTS   = 16,
  parameter int ENTRY_W = 16,
  parameter int PORTS   = 8,
  parameter int DATA_W  = 64
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      wide_mode,
  input logic                      wr_valid,
  input logic [$clog2(PORTS)-1:0]  wr_port,
  input logic [DATA_W-1:0]         wr_data,
  input logic [SLOTS*ENTRY_W-1:0]  tbl_entries,
  input logic [SLOTS-1:0]          tbl_valid,
  input logic [$clog2(SLOTS)-1:0]  rd_idx,
  input logic [ENTRY_W-1:0]        rd_entry,
  input logic                      rd_valid
);

  localparam int IDX_W        = $clog2(SLOTS);
  localparam int CMP_W        = IDX_W + 2;
  localparam int LANES        = DATA_W / ENTRY_W;
  localparam int NARROW_LANES = LANES / 2;

  logic [CMP_W-1:0]         cur_base;
  logic [CMP_W-1:0]         cur_limit;
  logic [SLOTS*ENTRY_W-1:0] cur_low_mask;

  logic                     prev_fire;
  logic [CMP_W-1:0]         prev_base;
  logic [CMP_W-1:0]         prev_limit;
  logic [ENTRY_W-1:0]       prev_lane0;
  logic [SLOTS*ENTRY_W-1:0] prev_low_mask;
  logic [SLOTS*ENTRY_W-1:0] prev_low_vals;
  logic [ENTRY_W-1:0]       base_slot_now;
  logic [ENTRY_W-1:0]       rd_slot_now;

  assign cur_base  = CMP_W'(wr_port) * CMP_W'(NARROW_LANES);
  assign cur_limit = cur_base + (wide_mode ? CMP_W'(LANES) : CMP_W'(NARROW_LANES));

  always_comb begin
    for (int s = 0; s < SLOTS; s++) begin
      cur_low_mask[s*ENTRY_W +: ENTRY_W] = (CMP_W'(s) < cur_base) ? '1 : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_fire     <= 1'b0;
      prev_base     <= '0;
      prev_limit    <= '0;
      prev_lane0    <= '0;
      prev_low_mask <= '0;
      prev_low_vals <= '0;
    end else begin
      prev_fire     <= wr_valid;
      prev_base     <= cur_base;
      prev_limit    <= cur_limit;
      prev_lane0    <= wr_data[ENTRY_W-1:0];
      prev_low_mask <= cur_low_mask;
      prev_low_vals <= tbl_entries & cur_low_mask;
    end
  end

  assign base_slot_now = tbl_entries[prev_base[IDX_W-1:0]*ENTRY_W +: ENTRY_W];
  assign rd_slot_now   = tbl_entries[rd_idx*ENTRY_W +: ENTRY_W];

  AST_RESET_EMPTY: assert property (@(posedge clk)
    !rst_n |-> (tbl_valid == '0 && tbl_entries == '0)); // R1

  AST_BASE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
    prev_fire |-> base_slot_now == prev_lane0); // R2

  AST_CLEAR_ABOVE: assert property (@(posedge clk) disable iff (!rst_n)
    prev_fire |-> ((tbl_valid >> prev_limit) == '0)); // R4

  AST_CLEAR_ABOVE_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    prev_fire |-> ((tbl_entries >> (prev_limit * ENTRY_W)) == '0)); // R4

  AST_BELOW_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    prev_fire |-> ((tbl_entries & prev_low_mask) == prev_low_vals)); // R5

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_valid |=> ($stable(tbl_entries) && $stable(tbl_valid))); // R8

  AST_READ_PORT: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_entry == rd_slot_now) && (rd_valid == tbl_valid[rd_idx])); // R10

  for (genvar s = 0; s < SLOTS; s++) begin : g_vchk
    AST_VALID_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
      tbl_valid[s] == (tbl_entries[s*ENTRY_W +: ENTRY_W] != '0)); // R7
  end

endmodule

bind rtag_table_loader rtag_table_loader_chk #(
  .SLOTS   (SLOTS),
  .ENTRY_W (ENTRY_W),
  .PORTS   (PORTS),
  .DATA_W  (DATA_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .wide_mode   (wide_mode),
  .wr_valid    (wr_valid),
  .wr_port     (wr_port),
  .wr_data     (wr_data),
  .tbl_entries (tbl_entries),
  .tbl_valid   (tbl_valid),
  .rd_idx      (rd_idx),
  .rd_entry    (rd_entry),
  .rd_valid    (rd_valid)
);

// File: tb/rtag_table_loader_bench.sv
module rtag_table_loader_bench;

  localparam int CLK_PERIOD = 10;
  localparam int SLOTS      = 16;
  localparam int ENTRY_W    = 16;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wide_mode;
  logic        wr_valid;
  logic        wr_ready;
  logic [2:0]  wr_port;
  logic [63:0] wr_data;
  logic [255:0] tbl_entries;
  logic [15:0] tbl_valid;
  logic [3:0]  rd_idx;
  logic [15:0] rd_entry;
  logic        rd_valid;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  logic [15:0] exp_e [SLOTS];
  logic        exp_v [SLOTS];

  always #(CLK_PERIOD/2) clk = ~clk;

  rtag_table_loader u_rtag_table_loader (
    .clk         (clk),
    .rst_n       (rst_n),
    .wide_mode   (wide_mode),
    .wr_valid    (wr_valid),
    .wr_ready    (wr_ready),
    .wr_port     (wr_port),
    .wr_data     (wr_data),
    .tbl_entries (tbl_entries),
    .tbl_valid   (tbl_valid),
    .rd_idx      (rd_idx),
    .rd_entry    (rd_entry),
    .rd_valid    (rd_valid)
  );

  // Model of one accepted write, written from the requirements
  task automatic model_write(input logic [2:0] p, input logic [63:0] d, input logic w);
    int base = p * 2;
    int span = w ? 4 : 2;
    for (int k = 0; k < span; k++) begin
      if (base + k < SLOTS) begin
        exp_e[base+k] = d[k*16 +: 16];
        exp_v[base+k] = (d[k*16 +: 16] != 16'h0);
      end
    end
    for (int s = base + span; s < SLOTS; s++) begin
      exp_e[s] = 16'h0;
      exp_v[s] = 1'b0;
    end
  endtask

  task automatic check_table(input string tag);
    for (int s = 0; s < SLOTS; s++) begin
      checks++;
      if (tbl_entries[s*ENTRY_W +: ENTRY_W] !== exp_e[s] || tbl_valid[s] !== exp_v[s]) begin
        errors++;
        $display("FAIL %s slot %0d: entry %h valid %b, expected entry %h valid %b",
                 tag, s, tbl_entries[s*ENTRY_W +: ENTRY_W], tbl_valid[s], exp_e[s], exp_v[s]);
      end
    end
  endtask

  task automatic check_bit(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  // One transfer, then sample at the following falling edge
  task automatic do_write(input logic [2:0] p, input logic [63:0] d, input logic w);
    @(negedge clk);
    wide_mode = w;
    wr_port   = p;
    wr_data   = d;
    wr_valid  = 1'b1;
    check_bit("R9 ready during transfer", wr_ready, 1'b1);
    @(negedge clk);
    wr_valid = 1'b0;
    model_write(p, d, w);
  endtask

  task automatic fill_wide();
    for (int p = 0; p < 8; p += 2) begin
      do_write(3'(p), {16'hA0+16'(p), 16'hB0+16'(p), 16'hC0+16'(p), 16'hD0+16'(p)}, 1'b1);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    wr_valid = 1'b0; wr_port = '0; wr_data = '0; wide_mode = 1'b0; rd_idx = '0;
    for (int s = 0; s < SLOTS; s++) begin exp_e[s] = '0; exp_v[s] = 1'b0; end
    repeat (3) @(negedge clk);
    check_table("R1 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    check_table("R1 after reset");
    check_bit("R9 ready out of reset", wr_ready, 1'b1);
  endtask

  task automatic t_wide();
    fill_wide();
    check_table("R3 wide fill");
  endtask

  task automatic t_narrow();
    // upper half nonzero: must be ignored in narrow mode (R2), slots 8..15 wiped (R4)
    do_write(3'd3, 64'hDEAD_BEEF_1234_5678, 1'b0);
    check_table("R2 R4 R5 narrow port 3");
    fill_wide();
    do_write(3'd0, 64'hFFFF_FFFF_0001_0002, 1'b0);
    check_table("R2 R4 narrow port 0");
  endtask

  task automatic t_wide_mid();
    fill_wide();
    do_write(3'd2, 64'h4444_3333_2222_1111, 1'b1);
    check_table("R3 R4 R5 wide port 2");
  endtask

  task automatic t_overflow();
    fill_wide();
    do_write(3'd7, 64'h9999_8888_7777_6666, 1'b1);
    check_table("R6 wide port 7 no wrap");
    do_write(3'd7, 64'h0000_0000_5555_4444, 1'b0);
    check_table("R6 narrow port 7");
  endtask

  task automatic t_zero_valid();
    fill_wide();
    do_write(3'd1, 64'h0000_0007_0000_0000, 1'b1);
    check_table("R7 zero lanes invalid");
  endtask

  task automatic t_idle();
    fill_wide();
    @(negedge clk);
    wr_valid = 1'b0; wr_port = 3'd0; wr_data = 64'h1; wide_mode = 1'b1;
    repeat (4) @(negedge clk);
    check_table("R8 idle ignores inputs");
  endtask

  task automatic t_back_to_back();
    fill_wide();
    @(negedge clk);
    wide_mode = 1'b1; wr_port = 3'd4; wr_data = 64'h0F0F_0E0E_0D0D_0C0C; wr_valid = 1'b1;
    @(negedge clk);
    model_write(3'd4, 64'h0F0F_0E0E_0D0D_0C0C, 1'b1);
    check_table("R8 first of back-to-back");
    wide_mode = 1'b0; wr_port = 3'd1; wr_data = 64'h0000_0000_0B0B_0A0A;
    @(negedge clk);
    wr_valid = 1'b0;
    model_write(3'd1, 64'h0000_0000_0B0B_0A0A, 1'b0);
    check_table("R8 second of back-to-back");
  endtask

  task automatic t_read_port();
    fill_wide();
    do_write(3'd5, 64'h0000_0000_0000_00EE, 1'b0);
    for (int s = 0; s < SLOTS; s++) begin
      rd_idx = 4'(s);
      #1;
      checks++;
      if (rd_entry !== exp_e[s] || rd_valid !== exp_v[s]) begin
        errors++;
        $display("FAIL R10 read slot %0d: got %h/%b expected %h/%b",
                 s, rd_entry, rd_valid, exp_e[s], exp_v[s]);
      end
    end
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_wide();
    t_narrow();
    t_wide_mid();
    t_overflow();
    t_zero_valid();
    t_idle();
    t_back_to_back();
    t_read_port();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule